// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running 12-bit timer count when a capture event arrives. Events come from two places. One is a hardware source: either an external pin or a comparator output, picked by a select input. The other is a software trigger written over a byte-wide register port. Hardware sources are asynchronous. They pass through a two-flop synchroniser, and only a rising edge counts as an event. Hardware capture happens only while the capture enable input is high.

Software reads the captured value one byte at a time. Reading a low byte also loads the matching high byte into one shared 8-bit holding register. A later high-byte read then returns a value taken at the same instant as the low byte. The same holding register serves every wide register in the unit. Here those are the capture register and a live view of the counter. Bit 7 of the capture high byte has two roles. Writing 1 to it forces a capture. Reading it shows whether the latest capture came from software (1) or from hardware (0). A one-cycle strobe marks each capture so that an external interrupt flag can be set.

Top module: `icap_unit`

## Requirements
- R1: Each capture loads the 12-bit count present on `cnt_i` at the capturing clock edge, and the captured value does not change between captures.
- R2: A hardware rising edge first sampled at clock edge n causes a capture at edge n+2, but only if `cap_en_i` is 1 at that edge; with `cap_en_i` at 0 a hardware edge causes no capture.
- R3: `src_sel_i` = 0 selects the pin as hardware source and `src_sel_i` = 1 selects the comparator; edges on the unselected source cause no capture.
- R4: A write (`wr_en_i`=1) to address 1 with data bit 7 set captures at that clock edge, whatever the value of `cap_en_i`; the same write with bit 7 clear has no effect.
- R5: Bit 7 of the capture high byte (address 1) reads 1 after a software capture and 0 after a hardware capture.
- R6: When a software write and a hardware event hit the same edge, exactly one capture occurs, the source flag reads 1 and the strobe lasts one cycle.
- R7: A read (`rd_en_i`=1) of address 0 returns capture bits 7:0 and loads the holding register with {flag, 3'b000, capture bits 11:8}; addresses 1 and 3 return the holding register.
- R8: The holding register is shared: a read of address 2 returns count bits 7:0 and loads it with {4'b0000, count bits 11:8}, replacing whatever a capture low read left there.
- R9: `cap_done_o` is 1 for exactly the cycle after each capturing edge, the same cycle in which the new value becomes readable.
- R10: While `rst_n` is 0 at a clock edge, the capture register, the source flag, the holding register and the strobe all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 12 | Free-running timer count |
| pin_i | input | 1 | Asynchronous external capture pin |
| cmp_i | input | 1 | Asynchronous comparator output |
| cap_en_i | input | 1 | Enables hardware-sourced capture |
| src_sel_i | input | 1 | Hardware source select: 0 pin, 1 comparator |
| addr_i | input | 2 | Register address: 0 capture low, 1 capture high, 2 count low, 3 count high |
| rd_en_i | input | 1 | Read strobe (updates holding register on low reads) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the presented address |
| cap_done_o | output | 1 | One-cycle capture strobe |

## Verification
The software trigger and a synchronised hardware edge can arrive on the same clock edge. The bench forces this by raising the pin two cycles before it writes the trigger bit, so that the synchronised edge lines up with the write. The result is judged by three things: a single strobe cycle, a source flag of 1, and a captured value equal to the count at that edge. A behavioural reference model runs alongside and compares the strobe and the read data on every cycle, so that any second capture or a wrong flag shows up at once.

// File: rtl/icap_pkg.sv
// Package: shared address codes, source selector encoding and source count
// for the input capture unit. Assumes a two-bit register address space.
package icap_pkg;

    localparam int ADDR_W     = 2;
    localparam int NUM_HW_SRC = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CAP_LO = 2'd0,
        A_CAP_HI = 2'd1,
        A_CNT_LO = 2'd2,
        A_CNT_HI = 2'd3
    } icap_addr_e;

    typedef enum logic {
        SEL_PIN = 1'b0,
        SEL_CMP = 1'b1
    } icap_sel_e;

endpackage

// File: rtl/icap_edge_sync.sv
// Module: icap_edge_sync
// Brings each asynchronous event input into the clock domain through
// SYNC_STAGES flops and flags a rising edge of the synchronised value.
// Assumes inputs are level signals that stay high for more than one clock.
module icap_edge_sync #(
    parameter int NUM_SRC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_i,
    output logic [NUM_SRC-1:0] rise_o
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            logic [SYNC_STAGES:0] chain_q;

            // Purpose: shift the raw input through the synchroniser plus one history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[SYNC_STAGES-1:0], async_i[g]};
                end
            end

            assign rise_o[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        end
    endgenerate

endmodule

// File: rtl/icap_capture.sv
// Module: icap_capture
// Holds the captured count, the source flag and the done strobe. Software
// trigger has priority over a hardware event on the same edge.
// Assumes rise_i is already synchronous to clk.
module icap_capture
    import icap_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int NUM_SRC = NUM_HW_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               sel_i,
    input  logic               en_i,
    input  logic               sw_trig_i,
    output logic [CNT_W-1:0]   cap_q,
    output logic               src_q,
    output logic               done_q
);

    logic hw_evt;

    // Purpose: pick the selected hardware edge and gate it with the enable.
    always_comb begin
        hw_evt = en_i & rise_i[sel_i];
    end

    // Purpose: load the count and record which source caused the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            src_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= sw_trig_i | hw_evt;
            if (sw_trig_i) begin
                cap_q <= cnt_i;
                src_q <= 1'b1;
            end else if (hw_evt) begin
                cap_q <= cnt_i;
                src_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/icap_regbus.sv
// Module: icap_regbus
// Byte-wide register access: decodes the software trigger, keeps the single
// shared holding byte for wide reads and drives the read mux.
// Assumes DATA_W < CNT_W <= 2*DATA_W-1 so that the flag fits above the high bits.
module icap_regbus
    import icap_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic              src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] temp_q,
    output logic              sw_trig_o
);

    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - 1 - HI_W;

    logic [DATA_W-1:0] cap_hi_byte;
    logic [DATA_W-1:0] cnt_hi_byte;
    logic              unused_wbits;

    assign cap_hi_byte  = {src_i, {PAD_W{1'b0}}, cap_i[CNT_W-1:DATA_W]};
    assign cnt_hi_byte  = {{(DATA_W-HI_W){1'b0}}, cnt_i[CNT_W-1:DATA_W]};
    assign unused_wbits = ^wdata_i[DATA_W-2:0];

    // Purpose: a write to the capture high byte with the top bit set triggers capture.
    always_comb begin
        sw_trig_o = wr_en_i && (addr_i == A_CAP_HI) && wdata_i[DATA_W-1];
    end

    // Purpose: low-byte reads load the shared holding byte with the partner high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (rd_en_i) begin
            case (addr_i)
                A_CAP_LO: temp_q <= cap_hi_byte;
                A_CNT_LO: temp_q <= cnt_hi_byte;
                default:  temp_q <= temp_q;
            endcase
        end
    end

    // Purpose: present the addressed byte; high addresses return the holding byte.
    always_comb begin
        case (addr_i)
            A_CAP_LO: rdata_o = cap_i[DATA_W-1:0];
            A_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
            default:  rdata_o = temp_q;
        endcase
    end

endmodule

// File: rtl/icap_unit.sv
// Module: icap_unit (top)
// Input capture unit: synchronises the hardware sources, captures the timer
// count on a selected edge or a software trigger, and serves byte reads.
// Assumes cnt_i is synchronous to clk.
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              pin_i,
    input  logic              cmp_i,
    input  logic              cap_en_i,
    input  logic              src_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cap_done_o
);

    logic [NUM_HW_SRC-1:0] raw_src;
    logic [NUM_HW_SRC-1:0] src_rise;
    logic [CNT_W-1:0]      cap_q;
    logic                  src_q;
    logic [DATA_W-1:0]     temp_q;
    logic                  sw_trig;

    // Index order follows the select encoding: SEL_PIN then SEL_CMP.
    assign raw_src = {cmp_i, pin_i};

    icap_edge_sync #(
        .NUM_SRC     (NUM_HW_SRC),
        .SYNC_STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_src),
        .rise_o  (src_rise)
    );

    icap_regbus #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .cap_i     (cap_q),
        .src_i     (src_q),
        .cnt_i     (cnt_i),
        .rdata_o   (rdata_o),
        .temp_q    (temp_q),
        .sw_trig_o (sw_trig)
    );

    icap_capture #(
        .CNT_W   (CNT_W),
        .NUM_SRC (NUM_HW_SRC)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_i),
        .rise_i    (src_rise),
        .sel_i     (src_sel_i),
        .en_i      (cap_en_i),
        .sw_trig_i (sw_trig),
        .cap_q     (cap_q),
        .src_q     (src_q),
        .done_q    (cap_done_o)
    );

endmodule

// File: rtl/icap_checker.sv
// Module: icap_checker
// Temporal properties of the capture unit, bound to the top module.
// Assumes the address encoding of icap_pkg.
module icap_checker
    import icap_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              cap_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              cap_done_o,
    input logic [CNT_W-1:0]  cap_q,
    input logic              src_q,
    input logic [DATA_W-1:0] temp_q
);

    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - 1 - HI_W;

    p_value_at_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done_o && $past(rst_n)) |-> (cap_q == $past(cnt_i)));

    p_no_hw_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cap_en_i) && !$past(wr_en_i && addr_i == A_CAP_HI && wdata_i[DATA_W-1]))
        |-> !cap_done_o);

    p_sw_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i && addr_i == A_CAP_HI && wdata_i[DATA_W-1]))
        |-> (cap_done_o && src_q));

    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_done_o |-> $stable(cap_q));

    p_temp_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en_i && addr_i == A_CAP_LO))
        |-> (temp_q == {$past(src_q), {PAD_W{1'b0}}, $past(cap_q[CNT_W-1:DATA_W])}));

endmodule

bind icap_unit icap_checker #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_icap_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .cap_en_i   (cap_en_i),
    .addr_i     (addr_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .cap_done_o (cap_done_o),
    .cap_q      (cap_q),
    .src_q      (src_q),
    .temp_q     (temp_q)
);

// File: tb/test_icap_unit.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenario checks tagged by requirement.
module test_icap_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cnt_i = 12'hF00;
    logic        pin_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic        cap_en_i = 1'b0;
    logic        src_sel_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wdata_i = 8'h00;
    logic [7:0]  rdata_o;
    logic        cap_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    logic [11:0] m_cap;
    logic        m_src;
    logic        m_done;
    logic [7:0]  m_tmp;
    int          pin_h[$];
    int          cmp_h[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    icap_unit i_icap_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_i),
        .pin_i      (pin_i),
        .cmp_i      (cmp_i),
        .cap_en_i   (cap_en_i),
        .src_sel_i  (src_sel_i),
        .addr_i     (addr_i),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .cap_done_o (cap_done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit sw, hw, evp, evc;
        if (!rst_n) begin
            m_cap = '0; m_src = 1'b0; m_tmp = '0; m_done = 1'b0;
            pin_h = '{0, 0, 0};
            cmp_h = '{0, 0, 0};
        end else begin
            evp = (pin_h[1] == 1) && (pin_h[0] == 0);
            evc = (cmp_h[1] == 1) && (cmp_h[0] == 0);
            sw  = wr_en_i && addr_i == 2'd1 && wdata_i[7];
            hw  = cap_en_i && (src_sel_i ? evc : evp);
            if (rd_en_i && addr_i == 2'd0) m_tmp = {m_src, 3'b000, m_cap[11:8]};
            else if (rd_en_i && addr_i == 2'd2) m_tmp = {4'h0, cnt_i[11:8]};
            if (sw) begin m_cap = cnt_i; m_src = 1'b1; end
            else if (hw) begin m_cap = cnt_i; m_src = 1'b0; end
            m_done = sw || hw;
            pin_h.push_back(int'(pin_i)); void'(pin_h.pop_front());
            cmp_h.push_back(int'(cmp_i)); void'(cmp_h.pop_front());
        end
    endtask

    // one clock: model update at the edge, comparison at the following negedge
    task automatic step();
        logic [7:0] exp_rd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        case (addr_i)
            2'd0:    exp_rd = m_cap[7:0];
            2'd2:    exp_rd = cnt_i[7:0];
            default: exp_rd = m_tmp;
        endcase
        chk("R9 model strobe", cap_done_o, m_done);
        chk("R7 model read data", rdata_o, exp_rd);
    endtask

    task automatic tick();
        step();
        cnt_i = cnt_i + 12'd37;
    endtask

    task automatic read_cap(output logic [11:0] v, output logic f, output logic [7:0] hi);
        logic [7:0] lo;
        addr_i = 2'd0; rd_en_i = 1'b1;
        #1 lo = rdata_o;
        tick();
        addr_i = 2'd1;
        #1 hi = rdata_o;
        tick();
        rd_en_i = 1'b0;
        v = {hi[3:0], lo};
        f = hi[7];
    endtask

    initial begin
        logic [11:0] exp_v, got_v, last_v;
        logic        got_f;
        logic [7:0]  got_hi;
        logic [3:0]  cnt_hi;

        // R10: reset state
        repeat (3) step();
        chk("R10 strobe in reset", cap_done_o, 1'b0);
        chk("R10 capture low in reset", rdata_o, 8'h00);
        rst_n = 1'b1;
        addr_i = 2'd1;
        tick();
        chk("R10 holding byte after reset", rdata_o, 8'h00);

        // R2/R1: enabled pin edge captures two edges after first sample
        cap_en_i = 1'b1; src_sel_i = 1'b0;
        pin_i = 1'b1;
        tick(); chk("R2 no capture at edge n", cap_done_o, 1'b0);
        tick(); chk("R2 no capture at edge n+1", cap_done_o, 1'b0);
        exp_v = cnt_i;
        tick(); chk("R2 capture at edge n+2", cap_done_o, 1'b1);
        pin_i = 1'b0;
        tick(); chk("R9 strobe single cycle", cap_done_o, 1'b0);
        read_cap(got_v, got_f, got_hi);
        chk("R1 captured count", got_v, exp_v);
        chk("R5 flag after hardware", got_f, 1'b0);
        chk("R7 pad bits zero", got_hi[6:4], 3'b000);
        last_v = exp_v;

        // R2: disabled pin edge ignored
        cap_en_i = 1'b0;
        pin_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick(); chk("R2 disabled no capture", cap_done_o, 1'b0);
        end
        pin_i = 1'b0;
        read_cap(got_v, got_f, got_hi);
        chk("R2 value held while disabled", got_v, last_v);

        // R3: comparator selected, pin ignored
        cap_en_i = 1'b1; src_sel_i = 1'b1;
        pin_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick(); chk("R3 unselected pin ignored", cap_done_o, 1'b0);
        end
        cmp_i = 1'b1;
        tick(); tick();
        exp_v = cnt_i;
        tick(); chk("R3 comparator capture", cap_done_o, 1'b1);
        cmp_i = 1'b0; pin_i = 1'b0;
        read_cap(got_v, got_f, got_hi);
        chk("R3 comparator value", got_v, exp_v);
        last_v = exp_v;

        // R4: software trigger with enable off
        cap_en_i = 1'b0; src_sel_i = 1'b0;
        addr_i = 2'd1; wdata_i = 8'h80; wr_en_i = 1'b1;
        exp_v = cnt_i;
        tick();
        wr_en_i = 1'b0;
        chk("R4 software capture", cap_done_o, 1'b1);
        read_cap(got_v, got_f, got_hi);
        chk("R4 software value", got_v, exp_v);
        chk("R5 flag after software", got_f, 1'b1);
        last_v = exp_v;

        // R4: write with bit 7 clear has no effect
        addr_i = 2'd1; wdata_i = 8'h7F; wr_en_i = 1'b1;
        tick();
        wr_en_i = 1'b0;
        chk("R4 bit7 clear no capture", cap_done_o, 1'b0);
        read_cap(got_v, got_f, got_hi);
        chk("R4 value unchanged", got_v, last_v);

        // R6: software and hardware on the same edge
        cap_en_i = 1'b1; src_sel_i = 1'b0;
        pin_i = 1'b1;
        tick(); tick();
        addr_i = 2'd1; wdata_i = 8'h80; wr_en_i = 1'b1;
        exp_v = cnt_i;
        tick();
        wr_en_i = 1'b0; pin_i = 1'b0;
        chk("R6 coincident capture", cap_done_o, 1'b1);
        tick();
        chk("R6 single strobe", cap_done_o, 1'b0);
        read_cap(got_v, got_f, got_hi);
        chk("R6 coincident value", got_v, exp_v);
        chk("R6 software wins flag", got_f, 1'b1);

        // R8: holding byte shared between wide registers
        rd_en_i = 1'b1; addr_i = 2'd0;
        tick();
        addr_i = 2'd2;
        cnt_hi = cnt_i[11:8];
        tick();
        rd_en_i = 1'b0;
        addr_i = 2'd1;
        #1 chk("R8 capture high shows count high", rdata_o, {4'h0, cnt_hi});
        addr_i = 2'd3;
        #1 chk("R8 count high address", rdata_o, {4'h0, cnt_hi});
        rd_en_i = 1'b1; addr_i = 2'd2;
        tick();
        addr_i = 2'd0;
        tick();
        rd_en_i = 1'b0;
        addr_i = 2'd3;
        #1 chk("R8 count high shows capture high", rdata_o, {1'b1, 3'b000, exp_v[11:8]});
        tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule